// File: doc/BRIEF.md
# FIFO Interrupt Bid Arbiter

This block tracks how full the transmit FIFO of each of two serial channels is and turns that fill state into an interrupt bid. A bid is a number that grows with the free space in the FIFO. It equals the count of free slots minus one, so an empty 256-entry FIFO bids 255, a FIFO with one free slot bids 0, and a full FIFO does not bid at all. A two-bit gate field for each channel can hold bidding back until a chosen amount of space has drained. The FIFO storage sits outside this block. The block only sees the same push and pop strobes that the storage sees.

Each channel also has a receive-side bid, which arrives on plain input ports. A small arbiter takes the four candidate bids and keeps only those strictly above a programmable threshold. The highest of these wins. An interrupt-acknowledge strobe or an update strobe loads the winner into a current-interrupt register, which records the channel, the source type and the bid value. If no candidate is above the threshold, the register loads all zeros. A zero type field therefore tells the host that nothing needs service.

Top module: `fifo_bid_arbiter`

## Requirements
- R1: Each channel holds a fill count of 0 to 256, which reset sets to 0. A push adds one unless the count is 256. A pop subtracts one unless the count is 0. Acceptance is judged on the count before the edge, so push and pop together at 256 leave 255, and push and pop together at 0 leave 1.
- R2: When a channel's bid is valid, its bid value equals 255 minus the fill count, which is the number of free slots minus one. When the bid is not valid, the bid value reads 0.
- R3: A channel whose fill count is 256 never presents a valid bid, whatever its gate field holds.
- R4: The 2-bit gate field allows a valid bid only when the free slots reach a set amount: code 0 needs at least 1, code 1 needs at least 16, code 2 needs at least 240, and code 3 needs all 256.
- R5: The bid outputs are registered. They reflect the fill count and the gate field sampled at the same clock edge, so the count and the bid change together.
- R6: On the rising edge where int_ack or cir_update is high, the current-interrupt register loads the candidate with the largest bid among those that are valid and strictly greater than thresh. The channel bit is 0 for A and 1 for B. The type is 01 for a receive source and 10 for a transmit source, and code 11 never occurs.
- R7: When several qualifying candidates share the largest bid, the winner follows this order: A receive, then A transmit, then B receive, then B transmit.
- R8: If no candidate qualifies at a strobe, the channel bit, the type and the bid all load 0. A type of 00 means that no source needs service.
- R9: Without a strobe, the current-interrupt register holds its value. Acknowledge and update load it the same way.
- R10: After reset, both fill counts read 0, both bids are valid with the value 255, and the current-interrupt register reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_push | input | 1 | Channel A transmit FIFO write strobe |
| a_pop | input | 1 | Channel A transmit FIFO read strobe |
| a_level | input | 2 | Channel A bid gate code |
| b_push | input | 1 | Channel B transmit FIFO write strobe |
| b_pop | input | 1 | Channel B transmit FIFO read strobe |
| b_level | input | 2 | Channel B bid gate code |
| a_rx_vld | input | 1 | Channel A receive bid present |
| a_rx_bid | input | 8 | Channel A receive bid value |
| b_rx_vld | input | 1 | Channel B receive bid present |
| b_rx_bid | input | 8 | Channel B receive bid value |
| thresh | input | 8 | Bid threshold; a bid must exceed it |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| cir_update | input | 1 | Current-interrupt update strobe |
| a_count | output | 9 | Channel A fill count |
| a_tx_vld | output | 1 | Channel A transmit bid valid |
| a_tx_bid | output | 8 | Channel A transmit bid value |
| b_count | output | 9 | Channel B fill count |
| b_tx_vld | output | 1 | Channel B transmit bid valid |
| b_tx_bid | output | 8 | Channel B transmit bid value |
| cir_chan | output | 1 | Winning channel (0 = A, 1 = B) |
| cir_type | output | 2 | Winning source type (00 none, 01 receive, 10 transmit) |
| cir_bid | output | 8 | Winning bid value |

## Verification
A monotonic fill of one channel past full, while the other channel pops while empty, tells counting apart from saturation at both ends. It also shows the bid falling to the top and then going silent. Drain-and-refill sweeps of every gate code separate the four free-space marks from one another. Directed ties, with all four candidates at 255 and subsets of them removed in turn, distinguish the fixed tie order from a plain highest-bid pick, and a threshold of 255 shows the all-zero load. A long random run mixes push, pop, gate changes, receive bids and strobes to catch interactions, such as simultaneous push and pop at the limits and a strobe landing on the edge where a bid changes.

// File: rtl/fbid_pkg.sv
package fbid_pkg;

  localparam int unsigned FB_NUM_CH = 2;
  localparam int unsigned FB_NSRC   = 2 * FB_NUM_CH;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_RX   = 2'b01,
    SRC_TX   = 2'b10
  } src_type_e;

  typedef enum logic [1:0] {
    GATE_ANY_FREE  = 2'd0,
    GATE_LOW_MARK  = 2'd1,
    GATE_HIGH_MARK = 2'd2,
    GATE_DRAINED   = 2'd3
  } gate_code_e;

endpackage

// File: rtl/fbid_tx_tracker.sv
module fbid_tx_tracker
  import fbid_pkg::*;
#(
  parameter int unsigned DEPTH      = 256,
  parameter int unsigned LVL1_EMPTY = 16,
  parameter int unsigned LVL2_EMPTY = 240,
  localparam int unsigned BID_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = BID_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [1:0]       level_i,
  output logic [CNT_W-1:0] count_o,
  output logic             bid_vld_o,
  output logic [BID_W-1:0] bid_o
);

  logic [CNT_W-1:0] count_q, count_d, free_d;
  logic             push_ok, pop_ok, gate_d;
  logic             vld_q;
  logic [BID_W-1:0] bid_q;
  gate_code_e       gate_code;

  // acceptance judged on the pre-edge count
  always_comb begin
    push_ok = push_i && (count_q != CNT_W'(DEPTH));
    pop_ok  = pop_i && (count_q != '0);
    count_d = count_q;
    if (push_ok && !pop_ok)
      count_d = count_q + CNT_W'(1);
    else if (pop_ok && !push_ok)
      count_d = count_q - CNT_W'(1);
  end

  // gate on the free space that will exist after this edge
  always_comb begin
    free_d    = CNT_W'(DEPTH) - count_d;
    gate_code = gate_code_e'(level_i);
    case (gate_code)
      GATE_ANY_FREE:  gate_d = (free_d >= CNT_W'(1));
      GATE_LOW_MARK:  gate_d = (free_d >= CNT_W'(LVL1_EMPTY));
      GATE_HIGH_MARK: gate_d = (free_d >= CNT_W'(LVL2_EMPTY));
      default:        gate_d = (free_d == CNT_W'(DEPTH));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      vld_q   <= 1'b1;
      bid_q   <= BID_W'(DEPTH - 1);
    end else begin
      count_q <= count_d;
      vld_q   <= gate_d;
      bid_q   <= gate_d ? BID_W'(CNT_W'(DEPTH - 1) - count_d) : '0;
    end
  end

  assign count_o   = count_q;
  assign bid_vld_o = vld_q;
  assign bid_o     = bid_q;

endmodule

// File: rtl/fbid_arbiter.sv
module fbid_arbiter #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned BID_W = 8,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            cand_vld,
  input  logic [NSRC-1:0][BID_W-1:0] cand_bid,
  input  logic [BID_W-1:0]           thresh,
  output logic                       win_vld,
  output logic [IDX_W-1:0]           win_idx,
  output logic [BID_W-1:0]           win_bid
);

  // lowest index keeps a tie: only a strictly larger bid displaces it
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_bid = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_vld[i] && (cand_bid[i] > thresh) &&
          (!win_vld || (cand_bid[i] > win_bid))) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_bid = cand_bid[i];
      end
    end
  end

endmodule

// File: rtl/fbid_cir_reg.sv
module fbid_cir_reg
  import fbid_pkg::*;
#(
  parameter int unsigned BID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             win_vld,
  input  logic [1:0]       win_idx,
  input  logic [BID_W-1:0] win_bid,
  output logic             chan_o,
  output logic [1:0]       type_o,
  output logic [BID_W-1:0] bid_o
);

  logic             chan_q;
  src_type_e        type_q;
  logic [BID_W-1:0] bid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= 1'b0;
      type_q <= SRC_NONE;
      bid_q  <= '0;
    end else if (load) begin
      if (win_vld) begin
        chan_q <= win_idx[1];
        type_q <= win_idx[0] ? SRC_TX : SRC_RX;
        bid_q  <= win_bid;
      end else begin
        chan_q <= 1'b0;
        type_q <= SRC_NONE;
        bid_q  <= '0;
      end
    end
  end

  assign chan_o = chan_q;
  assign type_o = type_q;
  assign bid_o  = bid_q;

endmodule

// File: rtl/fifo_bid_arbiter.sv
module fifo_bid_arbiter
  import fbid_pkg::*;
#(
  parameter int unsigned DEPTH      = 256,
  parameter int unsigned LVL1_EMPTY = 16,
  parameter int unsigned LVL2_EMPTY = 240,
  localparam int unsigned BID_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = BID_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_push,
  input  logic             a_pop,
  input  logic [1:0]       a_level,
  input  logic             b_push,
  input  logic             b_pop,
  input  logic [1:0]       b_level,
  input  logic             a_rx_vld,
  input  logic [BID_W-1:0] a_rx_bid,
  input  logic             b_rx_vld,
  input  logic [BID_W-1:0] b_rx_bid,
  input  logic [BID_W-1:0] thresh,
  input  logic             int_ack,
  input  logic             cir_update,
  output logic [CNT_W-1:0] a_count,
  output logic             a_tx_vld,
  output logic [BID_W-1:0] a_tx_bid,
  output logic [CNT_W-1:0] b_count,
  output logic             b_tx_vld,
  output logic [BID_W-1:0] b_tx_bid,
  output logic             cir_chan,
  output logic [1:0]       cir_type,
  output logic [BID_W-1:0] cir_bid
);

  localparam int unsigned IDX_W = $clog2(FB_NSRC);

  logic [FB_NUM_CH-1:0]            push_v, pop_v, tx_vld_v, rx_vld_v;
  logic [1:0]                      level_v  [FB_NUM_CH];
  logic [CNT_W-1:0]                count_v  [FB_NUM_CH];
  logic [BID_W-1:0]                tx_bid_v [FB_NUM_CH];
  logic [BID_W-1:0]                rx_bid_v [FB_NUM_CH];
  logic [FB_NSRC-1:0]              cand_vld;
  logic [FB_NSRC-1:0][BID_W-1:0]   cand_bid;
  logic                            win_vld;
  logic [IDX_W-1:0]                win_idx;
  logic [BID_W-1:0]                win_bid;

  assign push_v     = {b_push, a_push};
  assign pop_v      = {b_pop, a_pop};
  assign rx_vld_v   = {b_rx_vld, a_rx_vld};
  assign level_v[0] = a_level;
  assign level_v[1] = b_level;
  assign rx_bid_v[0] = a_rx_bid;
  assign rx_bid_v[1] = b_rx_bid;

  for (genvar g = 0; g < FB_NUM_CH; g++) begin : g_ch
    fbid_tx_tracker #(
      .DEPTH      (DEPTH),
      .LVL1_EMPTY (LVL1_EMPTY),
      .LVL2_EMPTY (LVL2_EMPTY)
    ) trk_i (
      .clk       (clk),
      .rst       (rst),
      .push_i    (push_v[g]),
      .pop_i     (pop_v[g]),
      .level_i   (level_v[g]),
      .count_o   (count_v[g]),
      .bid_vld_o (tx_vld_v[g]),
      .bid_o     (tx_bid_v[g])
    );

    // candidate order sets the tie priority: channel first, receive before transmit
    assign cand_vld[2*g]     = rx_vld_v[g];
    assign cand_bid[2*g]     = rx_bid_v[g];
    assign cand_vld[2*g + 1] = tx_vld_v[g];
    assign cand_bid[2*g + 1] = tx_bid_v[g];
  end

  fbid_arbiter #(
    .NSRC  (FB_NSRC),
    .BID_W (BID_W)
  ) arb_i (
    .cand_vld (cand_vld),
    .cand_bid (cand_bid),
    .thresh   (thresh),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_bid  (win_bid)
  );

  fbid_cir_reg #(
    .BID_W (BID_W)
  ) cir_i (
    .clk     (clk),
    .rst     (rst),
    .load    (int_ack | cir_update),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_bid (win_bid),
    .chan_o  (cir_chan),
    .type_o  (cir_type),
    .bid_o   (cir_bid)
  );

  assign a_count  = count_v[0];
  assign a_tx_vld = tx_vld_v[0];
  assign a_tx_bid = tx_bid_v[0];
  assign b_count  = count_v[1];
  assign b_tx_vld = tx_vld_v[1];
  assign b_tx_bid = tx_bid_v[1];

endmodule

// File: rtl/fifo_bid_arbiter_chk.sv
module fifo_bid_arbiter_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned BID_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = BID_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [BID_W-1:0] thresh,
  input logic             int_ack,
  input logic             cir_update,
  input logic [CNT_W-1:0] a_count,
  input logic             a_tx_vld,
  input logic [BID_W-1:0] a_tx_bid,
  input logic [CNT_W-1:0] b_count,
  input logic             b_tx_vld,
  input logic [BID_W-1:0] b_tx_bid,
  input logic             cir_chan,
  input logic [1:0]       cir_type,
  input logic [BID_W-1:0] cir_bid
);

  AST_A_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) a_count <= CNT_W'(DEPTH)); // R1
  AST_B_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) b_count <= CNT_W'(DEPTH)); // R1
  AST_A_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((a_count == $past(a_count)) || (a_count == $past(a_count) + CNT_W'(1)) ||
              (a_count == $past(a_count) - CNT_W'(1)))); // R1
  AST_A_FULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (a_count == CNT_W'(DEPTH)) |-> !a_tx_vld); // R3
  AST_B_FULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (b_count == CNT_W'(DEPTH)) |-> !b_tx_vld); // R3
  AST_A_EMPTY_TOP: assert property (@(posedge clk) disable iff (rst)
    (a_count == '0) |-> (a_tx_vld && (a_tx_bid == BID_W'(DEPTH - 1)))); // R4
  AST_A_BID_FREE: assert property (@(posedge clk) disable iff (rst)
    a_tx_vld |-> (a_tx_bid == BID_W'(CNT_W'(DEPTH - 1) - a_count))); // R2
  AST_B_BID_FREE: assert property (@(posedge clk) disable iff (rst)
    b_tx_vld |-> (b_tx_bid == BID_W'(CNT_W'(DEPTH - 1) - b_count))); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cir_type == 2'b00) |-> (!cir_chan && (cir_bid == '0))); // R8
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (rst) cir_type != 2'b11); // R6
  AST_WIN_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (int_ack || cir_update) |=> ((cir_type == 2'b00) || (cir_bid > $past(thresh)))); // R6
  AST_CIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(int_ack || cir_update) |=> $stable({cir_chan, cir_type, cir_bid})); // R9

endmodule

bind fifo_bid_arbiter fifo_bid_arbiter_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .thresh     (thresh),
  .int_ack    (int_ack),
  .cir_update (cir_update),
  .a_count    (a_count),
  .a_tx_vld   (a_tx_vld),
  .a_tx_bid   (a_tx_bid),
  .b_count    (b_count),
  .b_tx_vld   (b_tx_vld),
  .b_tx_bid   (b_tx_bid),
  .cir_chan   (cir_chan),
  .cir_type   (cir_type),
  .cir_bid    (cir_bid)
);

// File: tb/fifo_bid_arbiter_tb_top.sv
`timescale 1ns/1ps
module fifo_bid_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] push = '0, pop = '0, rxv = '0;
  logic [1:0] lvl0 = '0, lvl1 = '0;
  logic [7:0] rxb0 = '0, rxb1 = '0, thr = '0;
  logic       ack = 1'b0, upd = 1'b0;

  logic [8:0] a_count, b_count;
  logic       a_tx_vld, b_tx_vld, cir_chan;
  logic [7:0] a_tx_bid, b_tx_bid, cir_bid;
  logic [1:0] cir_type;

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  int    m_cnt [2];
  bit    m_vld [2];
  int    m_bid [2];
  string m_btag [2];
  int    m_chan, m_type, m_cbid;
  string m_ctag;

  always #2.5 clk = ~clk;

  fifo_bid_arbiter dut_i (
    .clk(clk), .rst(rst),
    .a_push(push[0]), .a_pop(pop[0]), .a_level(lvl0),
    .b_push(push[1]), .b_pop(pop[1]), .b_level(lvl1),
    .a_rx_vld(rxv[0]), .a_rx_bid(rxb0), .b_rx_vld(rxv[1]), .b_rx_bid(rxb1),
    .thresh(thr), .int_ack(ack), .cir_update(upd),
    .a_count(a_count), .a_tx_vld(a_tx_vld), .a_tx_bid(a_tx_bid),
    .b_count(b_count), .b_tx_vld(b_tx_vld), .b_tx_bid(b_tx_bid),
    .cir_chan(cir_chan), .cir_type(cir_type), .cir_bid(cir_bid)
  );

  function automatic int need_free(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 240;
      default: return 256;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int nc, fr, best, ties;
    int cb [4];
    bit cv [4];
    logic [1:0] lv;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] <= 0; m_vld[c] <= 1; m_bid[c] <= 255; m_btag[c] <= "R10";
      end
      m_chan <= 0; m_type <= 0; m_cbid <= 0; m_ctag <= "R10";
    end else begin
      cv[0] = rxv[0]; cb[0] = rxb0; cv[1] = m_vld[0]; cb[1] = m_bid[0];
      cv[2] = rxv[1]; cb[2] = rxb1; cv[3] = m_vld[1]; cb[3] = m_bid[1];
      for (int c = 0; c < 2; c++) begin
        nc = m_cnt[c];
        if (push[c] && m_cnt[c] < 256) nc = nc + 1;
        if (pop[c] && m_cnt[c] > 0) nc = nc - 1;
        lv = (c == 0) ? lvl0 : lvl1;
        fr = 256 - nc;
        m_cnt[c] <= nc;
        m_vld[c] <= (fr >= need_free(lv));
        m_bid[c] <= (fr >= need_free(lv)) ? fr - 1 : 0;
        m_btag[c] <= (nc == 256) ? "R3" : (lv != 0) ? "R4" : "R2";
      end
      if (ack || upd) begin
        best = -1;
        for (int i = 0; i < 4; i++)
          if (cv[i] && cb[i] > thr && (best < 0 || cb[i] > cb[best])) best = i;
        if (best < 0) begin
          m_chan <= 0; m_type <= 0; m_cbid <= 0; m_ctag <= "R8";
        end else begin
          ties = 0;
          for (int i = 0; i < 4; i++)
            if (cv[i] && cb[i] > thr && cb[i] == cb[best]) ties++;
          m_chan <= best / 2;
          m_type <= (best % 2 == 0) ? 1 : 2;
          m_cbid <= cb[best];
          m_ctag <= (ties > 1) ? "R7" : "R6";
        end
      end else begin
        m_ctag <= "R9";
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // outputs compared every cycle away from the active edge (R5: count and bid in step)
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1", "a_count", a_count, m_cnt[0]);
      chk("R1", "b_count", b_count, m_cnt[1]);
      chk(m_btag[0], "a_tx_vld", a_tx_vld, m_vld[0]);
      chk(m_btag[0], "a_tx_bid", a_tx_bid, m_bid[0]);
      chk(m_btag[1], "b_tx_vld", b_tx_vld, m_vld[1]);
      chk(m_btag[1], "b_tx_bid", b_tx_bid, m_bid[1]);
      chk(m_ctag, "cir_chan", cir_chan, m_chan);
      chk(m_ctag, "cir_type", cir_type, m_type);
      chk(m_ctag, "cir_bid", cir_bid, m_cbid);
    end
  end

  task automatic idle();
    push = '0; pop = '0; ack = 0; upd = 0;
  endtask

  task automatic strobe_check(input int exp_chan, input int exp_type, input int exp_bid, input string tag);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk(tag, "cir_chan directed", cir_chan, exp_chan);
    chk(tag, "cir_type directed", cir_type, exp_type);
    chk(tag, "cir_bid directed", cir_bid, exp_bid);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: reset state before any further edge
    chk("R10", "a_count rst", a_count, 0);
    chk("R10", "a_tx_vld rst", a_tx_vld, 1);
    chk("R10", "a_tx_bid rst", a_tx_bid, 255);
    chk("R10", "b_tx_bid rst", b_tx_bid, 255);
    chk("R10", "cir_type rst", cir_type, 0);
    chk("R10", "cir_bid rst", cir_bid, 0);
    cmp_on = 1;

    // fill A past full, B pops while empty (R1, R2, R3)
    thr = 100;
    for (int i = 0; i < 262; i++) begin
      @(negedge clk); push = 2'b01; pop = 2'b10; ack = (i % 16 == 0);
    end
    @(negedge clk); idle();
    @(negedge clk);
    chk("R3", "a_tx_vld full", a_tx_vld, 0);
    chk("R1", "a_count full", a_count, 256);
    // simultaneous push and pop at both limits (R1)
    push = 2'b11; pop = 2'b11;
    @(negedge clk); idle();
    chk("R1", "a_count full push+pop", a_count, 255);
    chk("R1", "b_count empty push+pop", b_count, 1);
    chk("R2", "a_tx_bid one free", a_tx_bid, 0);

    // gate code sweep: drain then refill A, update strobes (R4)
    for (int lv = 0; lv < 4; lv++) begin
      lvl0 = 2'(lv); lvl1 = 2'(3 - lv); thr = 8'(lv * 60);
      for (int i = 0; i < 260; i++) begin
        @(negedge clk); pop = 2'b01; push = 2'b00; upd = (i % 7 == 0);
      end
      for (int i = 0; i < 260; i++) begin
        @(negedge clk); pop = 2'b00; push = 2'b11; upd = (i % 9 == 0);
      end
      for (int i = 0; i < 130; i++) begin
        @(negedge clk); pop = 2'b11; push = 2'b00; upd = 0;
      end
    end
    @(negedge clk); idle();

    // directed ties: drain both to empty, gate any-free, so both tx bids are 255 (R7)
    lvl0 = 0; lvl1 = 0;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk); pop = 2'b11;
    end
    @(negedge clk); idle();
    rxv = 2'b11; rxb0 = 255; rxb1 = 255; thr = 254;
    strobe_check(0, 1, 255, "R7");
    rxv = 2'b10;
    strobe_check(0, 2, 255, "R7");
    lvl0 = 3; push = 2'b01; @(negedge clk); idle();
    strobe_check(1, 1, 255, "R7");
    rxv = 2'b00;
    strobe_check(1, 2, 255, "R6");
    thr = 255;
    strobe_check(0, 0, 0, "R8");
    thr = 10; rxv = 2'b01; rxb0 = 11;
    lvl1 = 3; push = 2'b10; @(negedge clk); idle();
    strobe_check(0, 1, 11, "R6");
    thr = 11;
    strobe_check(0, 0, 0, "R8");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (i % 1500 < 750) begin
        push = 2'($urandom_range(0, 3) != 0 ? 2'b11 : 2'b00) & 2'($urandom_range(0, 3));
        pop  = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      end else begin
        pop  = 2'($urandom_range(0, 3) != 0 ? 2'b11 : 2'b00) & 2'($urandom_range(0, 3));
        push = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      end
      if (i % 97 == 0) begin
        lvl0 = 2'($urandom_range(0, 3)); lvl1 = 2'($urandom_range(0, 3));
      end
      rxv  = 2'($urandom_range(0, 3));
      rxb0 = 8'($urandom_range(0, 255));
      rxb1 = ($urandom_range(0, 3) == 0) ? rxb0 : 8'($urandom_range(0, 255));
      thr  = 8'($urandom_range(0, 255));
      ack  = ($urandom_range(0, 4) == 0);
      upd  = ($urandom_range(0, 6) == 0);
    end
    @(negedge clk); idle(); rxv = '0;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule